// File: doc/BRIEF.md
# Strobe Delay Sweep Edge Finder

This block locates the rising edge of a sampled receive strobe by walking a delay code across its whole range. For every code it clears the sampling path, clears the sample counters and then opens a measurement window of fixed length. After the window closes it takes two counts from the sampling logic: the total number of samples and the number of samples seen high. From these it decides whether the strobe was low or high at that delay.

A level tracker starts each sweep in an unknown state. Only a high reading that directly follows a low reading counts as an edge. When reference checking is on, an edge at or below a reference delay is thrown away and the tracker goes back to unknown, so the sweep carries on. The sweep ends at the first accepted edge, or at the top code with a failure flag. The delay line and the counters are outside the block.

Top module: `dly_edge_sweep`

## Requirements
- R1: A sweep starts at delay code 0 and goes up by exactly 1 per step. It does not go past 2^DLY_W-1 (511 by default). `dly_code` holds one value for all of a step.
- R2: Each step runs in this order: `path_rst` high for one cycle, then `cnt_rst` high for one cycle, then `scan_en` high for exactly WIN_CYC consecutive cycles. No two of these three outputs are ever high in the same cycle.
- R3: The counts are taken only on a cycle with `cnt_valid` high that comes after the window has closed. A `cnt_valid` pulse while the window is open has no effect on the result.
- R4: A step reads low when `high_cnt` < (`samp_cnt` >> 1), compared unsigned. Otherwise it reads high. For example, samp_cnt=7 with high_cnt=3 reads high, and high_cnt=2 reads low.
- R5: The tracker is unknown at the start of each sweep. A high reading while the tracker is unknown is not an edge and leaves the tracker unknown. A low reading makes the tracker low.
- R6: At the first accepted low-to-high change, the sweep stops and no further step is started. `done` pulses, `fail` is 0 and `edge_delay` is that step's code.
- R7: `ref_chk_en` and `ref_dly` are captured when `start` is taken. With the check enabled, a change found at a code less than or equal to the captured reference is rejected. The tracker returns to unknown and the sweep continues with the next code.
- R8: If the last code is evaluated without an accepted edge, `done` pulses with `fail`=1 and `edge_delay`=0.
- R9: `done` is high for a single cycle. `edge_delay` and `fail` hold their values until the next sweep completes. A `start` pulse during a sweep is ignored.
- R10: After reset the block is idle. All outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a sweep when the block is idle |
| ref_chk_en | input | 1 | Enables rejection of edges at or below the reference |
| ref_dly | input | DLY_W | Reference delay code |
| dly_code | output | DLY_W | Delay code driven to the delay line |
| path_rst | output | 1 | Sampling-path reset pulse |
| cnt_rst | output | 1 | Sample-counter reset pulse |
| scan_en | output | 1 | Measurement window enable |
| samp_cnt | input | CNT_W | Total sample count |
| high_cnt | input | CNT_W | Count of samples seen high |
| cnt_valid | input | 1 | Qualifies the two counts |
| edge_delay | output | DLY_W | Code of the accepted edge |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No edge found in the sweep |

## Verification
The bench targets these corner cases. An edge exactly at the reference must be rejected; a design that compares with strictly-less would wrongly accept it. After a rejection, a long run of high readings must not be reported as an edge, because the tracker has lost its low state. A design that returned to low instead of unknown would report an edge at the very next code. The bench also puts counts exactly at half and one below half with odd sample totals, which catches rounding errors and off-by-one errors in the threshold. Further cases cover edges at codes 1 and 511, all-high and all-low sweeps that must fail, a stray count strobe inside the window, and a restart attempt in the middle of a sweep that would otherwise change the step count.

// File: rtl/dsw_pkg.sv
// Shared types for the delay-sweep edge finder.
package dsw_pkg;
    // Sequencer phases of one delay step.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRST,
        ST_CRST,
        ST_SCAN,
        ST_WAIT
    } seq_st_t;

    // Tracked strobe level; high is never stored, it either forms an edge or resets.
    typedef enum logic {
        LV_UNKNOWN,
        LV_LOW
    } lvl_t;
endpackage

// File: rtl/dsw_win_timer.sv
// Measurement window timer. It is loaded one cycle before the window opens.
// While run is high it counts down, and it flags the last window cycle.
// Assumes WIN_CYC >= 1.
module dsw_win_timer #(
    parameter int WIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int TW = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);

    logic [TW-1:0] cnt_q;

    // Load remaining cycles, then count down while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= TW'(WIN_CYC - 1);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && (cnt_q == '0);
endmodule

// File: rtl/dsw_level_cls.sv
// Level classifier. It reads high unless the high count is below half the total.
// Pure combinational logic; assumes unsigned counts.
module dsw_level_cls #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] samp_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    output logic             is_high
);
    logic [CNT_W-1:0] half;

    // Threshold is the total count shifted right by one.
    always_comb begin
        half    = samp_cnt >> 1;
        is_high = !(high_cnt < half);
    end
endmodule

// File: rtl/dsw_edge_track.sv
// Level tracker and edge qualifier. It reports an accepted low-to-high change.
// An edge that fails the reference check is dropped, and every high reading
// returns the tracker to unknown. Assumes upd is a single-cycle strobe.
module dsw_edge_track
    import dsw_pkg::*;
#(
    parameter int DLY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic             is_high,
    input  logic [DLY_W-1:0] dly,
    input  logic             ref_en,
    input  logic [DLY_W-1:0] ref_dly,
    output logic             hit
);
    lvl_t lvl_q;
    logic accept;

    // Candidate passes when checking is off or it lies beyond the reference.
    always_comb begin
        accept = !ref_en || (dly > ref_dly);
        hit    = upd && is_high && (lvl_q == LV_LOW) && accept;
    end

    // Low readings arm the tracker, high readings always disarm it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LV_UNKNOWN;
        end else if (clr) begin
            lvl_q <= LV_UNKNOWN;
        end else if (upd) begin
            lvl_q <= is_high ? LV_UNKNOWN : LV_LOW;
        end
    end

    // R5: after any high reading the tracker cannot still be armed.
    assert_high_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && is_high && !clr) |=> (lvl_q == LV_UNKNOWN));

    // R5: a new sweep always starts from unknown.
    assert_clear_unknown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lvl_q == LV_UNKNOWN));
endmodule

// File: rtl/dsw_seq.sv
// Step sequencer. It holds the delay code, drives the reset and window strobes,
// waits for counts and ends the sweep on an accepted edge or on the last code.
// Assumes cnt_valid arrives some time after scan_en falls.
module dsw_seq
    import dsw_pkg::*;
#(
    parameter int DLY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ref_chk_en,
    input  logic [DLY_W-1:0] ref_dly,
    input  logic             cnt_valid,
    input  logic             win_expire,
    input  logic             hit,
    output logic             path_rst,
    output logic             cnt_rst,
    output logic             scan_en,
    output logic             win_load,
    output logic             upd,
    output logic             clr,
    output logic             ref_en_q,
    output logic [DLY_W-1:0] ref_q,
    output logic [DLY_W-1:0] dly_code,
    output logic [DLY_W-1:0] edge_delay,
    output logic             done,
    output logic             fail
);
    localparam logic [DLY_W-1:0] LAST_CODE = '1;

    seq_st_t          st_q;
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] edge_q;
    logic             done_q;
    logic             fail_q;

    // Decode phase strobes and tracker controls from the state.
    always_comb begin
        path_rst = (st_q == ST_PRST);
        cnt_rst  = (st_q == ST_CRST);
        scan_en  = (st_q == ST_SCAN);
        win_load = (st_q == ST_CRST);
        upd      = (st_q == ST_WAIT) && cnt_valid;
        clr      = (st_q == ST_IDLE) && start;
    end

    // Advance through the phases of each step and close the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            dly_q    <= '0;
            edge_q   <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            ref_en_q <= 1'b0;
            ref_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        dly_q    <= '0;
                        ref_en_q <= ref_chk_en;
                        ref_q    <= ref_dly;
                        st_q     <= ST_PRST;
                    end
                end
                ST_PRST: st_q <= ST_CRST;
                ST_CRST: st_q <= ST_SCAN;
                ST_SCAN: begin
                    if (win_expire) begin
                        st_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cnt_valid) begin
                        if (hit) begin
                            done_q <= 1'b1;
                            fail_q <= 1'b0;
                            edge_q <= dly_q;
                            st_q   <= ST_IDLE;
                        end else if (dly_q == LAST_CODE) begin
                            done_q <= 1'b1;
                            fail_q <= 1'b1;
                            edge_q <= '0;
                            st_q   <= ST_IDLE;
                        end else begin
                            dly_q <= dly_q + 1'b1;
                            st_q  <= ST_PRST;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign dly_code   = dly_q;
    assign edge_delay = edge_q;
    assign done       = done_q;
    assign fail       = fail_q;

    // R1: inside a sweep the code holds or moves up by one.
    assert_code_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |->
        (dly_q == $past(dly_q) || dly_q == $past(dly_q) + 1'b1));

    // R2: counter reset always follows the path reset.
    assert_cnt_after_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |-> $past(path_rst));

    // R2: the window opens only right after the counter reset.
    assert_win_after_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en) |-> $past(cnt_rst));

    // R9: completion is a one-cycle pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: failure is only reported after the last code.
    assert_fail_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (dly_q == LAST_CODE));
endmodule

// File: rtl/dly_edge_sweep.sv
// Top of the delay-sweep edge finder. It joins the sequencer, window timer,
// level classifier and tracker. Assumes the counts are stable while cnt_valid is high.
module dly_edge_sweep #(
    parameter int DLY_W   = 9,
    parameter int CNT_W   = 16,
    parameter int WIN_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ref_chk_en,
    input  logic [DLY_W-1:0] ref_dly,
    output logic [DLY_W-1:0] dly_code,
    output logic             path_rst,
    output logic             cnt_rst,
    output logic             scan_en,
    input  logic [CNT_W-1:0] samp_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic             cnt_valid,
    output logic [DLY_W-1:0] edge_delay,
    output logic             done,
    output logic             fail
);
    logic             win_load;
    logic             win_expire;
    logic             upd;
    logic             clr;
    logic             is_high;
    logic             hit;
    logic             ref_en_q;
    logic [DLY_W-1:0] ref_q;

    dsw_seq #(.DLY_W(DLY_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ref_chk_en (ref_chk_en),
        .ref_dly    (ref_dly),
        .cnt_valid  (cnt_valid),
        .win_expire (win_expire),
        .hit        (hit),
        .path_rst   (path_rst),
        .cnt_rst    (cnt_rst),
        .scan_en    (scan_en),
        .win_load   (win_load),
        .upd        (upd),
        .clr        (clr),
        .ref_en_q   (ref_en_q),
        .ref_q      (ref_q),
        .dly_code   (dly_code),
        .edge_delay (edge_delay),
        .done       (done),
        .fail       (fail)
    );

    dsw_win_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (win_load),
        .run    (scan_en),
        .expire (win_expire)
    );

    dsw_level_cls #(.CNT_W(CNT_W)) u_cls (
        .samp_cnt (samp_cnt),
        .high_cnt (high_cnt),
        .is_high  (is_high)
    );

    dsw_edge_track #(.DLY_W(DLY_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .upd     (upd),
        .is_high (is_high),
        .dly     (dly_code),
        .ref_en  (ref_en_q),
        .ref_dly (ref_q),
        .hit     (hit)
    );

    // R7: an accepted edge under reference checking lies above the reference.
    assert_edge_above_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail && ref_en_q) |-> (edge_delay > ref_q));

    // R6: a successful sweep reports the code of its final step.
    assert_edge_is_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (edge_delay == dly_code));
endmodule

// File: tb/dly_edge_sweep_test.sv
`timescale 1ns/1ps
module dly_edge_sweep_test;
    localparam int DW = 9;
    localparam int CW = 16;
    localparam int WIN = 8;
    localparam int LAT = 2;
    localparam int NSTEP = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ref_chk_en = 1'b0;
    logic [DW-1:0] ref_dly = '0;
    logic [CW-1:0] samp_cnt = '0;
    logic [CW-1:0] high_cnt = '0;
    logic cnt_valid = 1'b0;
    logic [DW-1:0] dly_code, edge_delay;
    logic path_rst, cnt_rst, scan_en, done, fail;

    int checks = 0;
    int errors = 0;
    bit prof [NSTEP];
    int bmode = 0;
    bit spur_en = 0;
    int steps = 0;
    int mon_err = 0;
    int wincnt = 0;

    always #2.5 clk = ~clk;

    dly_edge_sweep #(.DLY_W(DW), .CNT_W(CW), .WIN_CYC(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_chk_en(ref_chk_en),
        .ref_dly(ref_dly), .dly_code(dly_code), .path_rst(path_rst),
        .cnt_rst(cnt_rst), .scan_en(scan_en), .samp_cnt(samp_cnt),
        .high_cnt(high_cnt), .cnt_valid(cnt_valid), .edge_delay(edge_delay),
        .done(done), .fail(fail)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Count pair for a given level; mode 1 puts counts exactly on the threshold.
    function automatic void mk_counts(input bit hi, output logic [CW-1:0] s,
                                      output logic [CW-1:0] h);
        int ss, hh, half;
        if (bmode == 1) begin
            ss = 2 * $urandom_range(200, 20) + 1;
            half = ss >> 1;
            hh = hi ? half : half - 1;
        end else begin
            ss = $urandom_range(1000, 64);
            half = ss >> 1;
            hh = hi ? $urandom_range(ss, half) : $urandom_range(half - 1, 0);
        end
        s = CW'(ss);
        h = CW'(hh);
    endfunction

    // Expected sweep outcome from the profile and the requirements.
    function automatic void expect_res(input bit ren, input int rf,
                                       output bit found, output int e);
        int lvl = 0;
        found = 0;
        e = 0;
        for (int d = 0; d < NSTEP; d++) begin
            if (!prof[d]) begin
                lvl = 1;
            end else begin
                if (lvl == 1 && (!ren || d > rf)) begin
                    found = 1;
                    e = d;
                    return;
                end
                lvl = 0;
            end
        end
    endfunction

    // Sampling counter model: counts arrive LAT cycles after the window closes.
    initial begin
        int lat = 0;
        bit ps = 0;
        logic [CW-1:0] s, h;
        forever begin
            @(negedge clk);
            cnt_valid = 1'b0;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    mk_counts(prof[dly_code], s, h);
                    samp_cnt = s;
                    high_cnt = h;
                    cnt_valid = 1'b1;
                end
            end
            if (ps && !scan_en) lat = LAT;
            if (spur_en && scan_en && !ps) begin
                mk_counts(!prof[dly_code], s, h);
                samp_cnt = s;
                high_cnt = h;
                cnt_valid = 1'b1;
            end
            ps = scan_en;
        end
    end

    // Step protocol monitor for code order and strobe sequence.
    initial begin
        bit pp = 0, pc = 0, ps = 0;
        forever begin
            @(negedge clk);
            if (path_rst) begin
                if (int'(dly_code) != steps) mon_err++;
                steps++;
            end
            if (cnt_rst && !pp) mon_err++;
            if (scan_en && !ps && !pc) mon_err++;
            if (scan_en) wincnt++;
            if (ps && !scan_en) begin
                if (wincnt != WIN) mon_err++;
                wincnt = 0;
            end
            if ((int'(path_rst) + int'(cnt_rst) + int'(scan_en)) > 1) mon_err++;
            pp = path_rst;
            pc = cnt_rst;
            ps = scan_en;
        end
    end

    task automatic run_case(input string req, input bit ren, input int rf,
                            input bit poke);
        bit f;
        int e, n, exp_steps;
        logic [DW-1:0] held;
        expect_res(ren, rf, f, e);
        exp_steps = f ? e + 1 : NSTEP;
        @(negedge clk);
        ref_chk_en = ren;
        ref_dly = DW'(rf);
        steps = 0;
        mon_err = 0;
        wincnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 40000) begin
            @(negedge clk);
            n++;
            if (poke && n == 300) begin
                start = 1'b1;
                ref_chk_en = 1'b0;
                ref_dly = '0;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(done == 1'b1, req, "done seen", int'(done), 1);
        chk(fail == !f, req, "fail flag", int'(fail), int'(!f));
        chk(int'(edge_delay) == (f ? e : 0), req, "edge_delay", int'(edge_delay), f ? e : 0);
        chk(steps == exp_steps, "R1", "steps taken", steps, exp_steps);
        chk(mon_err == 0, "R2", "step protocol errors", mon_err, 0);
        held = edge_delay;
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        chk(edge_delay == held, "R9", "edge_delay held", int'(edge_delay), int'(held));
        chk(dly_code == (f ? DW'(e) : '1) , "R1", "final code", int'(dly_code), f ? e : NSTEP - 1);
    endtask

    initial begin
        #950000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5a17);
        repeat (4) @(negedge clk);
        chk(done == 0, "R10", "reset done", int'(done), 0);
        chk(fail == 0, "R10", "reset fail", int'(fail), 0);
        chk(edge_delay == 0, "R10", "reset edge_delay", int'(edge_delay), 0);
        chk(dly_code == 0, "R10", "reset dly_code", int'(dly_code), 0);
        chk((path_rst | cnt_rst | scan_en) == 0, "R10", "reset strobes",
            int'(path_rst | cnt_rst | scan_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int d = 0; d < NSTEP; d++) prof[d] = (d >= 100);
        run_case("R6", 0, 0, 0);
        run_case("R7", 1, 100, 0);       // edge at reference rejected; rest high: R8 fail
        spur_en = 1;
        run_case("R3", 0, 0, 0);
        spur_en = 0;
        run_case("R9", 1, 50, 1);        // restart attempt mid-sweep ignored

        for (int d = 0; d < NSTEP; d++) prof[d] = (d >= 50 && d < 60) || d >= 200;
        run_case("R7", 1, 50, 0);
        run_case("R7", 1, 49, 0);
        run_case("R6", 0, 0, 0);

        for (int d = 0; d < NSTEP; d++) prof[d] = 1'b1;
        run_case("R5", 0, 0, 0);
        for (int d = 0; d < NSTEP; d++) prof[d] = 1'b0;
        run_case("R8", 0, 0, 0);

        for (int d = 0; d < NSTEP; d++) prof[d] = (d == NSTEP - 1);
        run_case("R1", 0, 0, 0);
        for (int d = 0; d < NSTEP; d++) prof[d] = (d >= 1);
        run_case("R5", 0, 0, 0);

        bmode = 1;
        for (int d = 0; d < NSTEP; d++) prof[d] = (d >= 300) || (d < 20);
        run_case("R4", 0, 0, 0);
        bmode = 0;

        for (int r = 0; r < 4; r++) begin
            bit lv;
            lv = 1'($urandom_range(1, 0));
            for (int d = 0; d < NSTEP; d++) begin
                if ($urandom_range(39, 0) == 0) lv = !lv;
                prof[d] = lv;
            end
            run_case("R6", 1'($urandom_range(1, 0)), $urandom_range(300, 0), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule